// File: doc/BRIEF.md
# Buck Switch Timing Sequencer

This block is the digital timing core for one channel of a synchronous step-down power stage. It decides, on every cycle of a fast system clock, whether the high-side switch is on, whether the low-side switch is fully on, and whether the low-side device sits in its weak current-source state. The analog comparators, error amplifier, slope ramp and power devices sit outside. They reach the block only as single-bit flags, already synchronised to the fast clock. The same clock also counts the dead time and the minimum on time.

The channel runs in one of two regimes. In fixed-frequency operation each cycle-clock pulse starts a high-side pulse, which ends when the PWM comparator trips. If that comparator never trips, the high side simply stays on and the duty reaches 100%. In light-load pulse-frequency operation a pulse starts whenever the low-output comparator asks for one. It lasts exactly the minimum on time and is followed by low-side conduction until the inductor current reaches zero. A current-limit trip always cuts the high side. Automatic regime selection can be overridden by a forced-PWM input, and the enable input parks everything off. The block carries no data stream: every pin is a plain level or a one-clock pulse, so there is no valid/ready handshake and no back-pressure.

Top module: `buck_switch_seq`

## Requirements
- R1: After reset, and on the clock after `en` is seen low, `hs_on`, `ls_on` and `ls_weak` are all 0. While `en` is low, cycle pulses start nothing.
- R2: In fixed-frequency operation a `cyc_tick` pulse seen while the high side is off turns `hs_on` on at the next clock. A `pwm_trip` seen while `hs_on` is high turns it off at the next clock.
- R3: When `hs_on` falls, `ls_on` rises exactly DEAD_CYC clocks later (default 3). `hs_on` and `ls_on` are never high together.
- R4: An `ilim_trip` seen while `hs_on` is high turns `hs_on` off at the next clock, whatever the PWM comparator shows.
- R5: While `pwm_trip` stays low, `hs_on` stays high across any number of `cyc_tick` pulses (100% duty).
- R6: With `force_pwm` low, light-load operation begins at the end of the ENTRY_CNT-th consecutive (default 4) PWM pulse ended by `pwm_trip` after at most MIN_ON_CYC clocks (default 8) of high-side time. A pulse longer than MIN_ON_CYC clocks, or one ended by `ilim_trip`, restarts the count.
- R7: In light-load operation, `pfm_low` seen while the high side is off starts a pulse at the next clock, with no cycle pulse needed. `hs_on` then stays high for exactly MIN_ON_CYC clocks whatever `pwm_trip` does, and `ls_weak` is high throughout.
- R8: After a light-load pulse and the dead time, `ls_on` is high. `zc_det` turns `ls_on` off and `ls_weak` on at the next clock.
- R9: In light-load operation, a `pfm_low` request with no `cyc_tick` since the previous pulse started ends light-load operation. The pulse it starts is a PWM pulse: `ls_weak` is low and the pulse ends on `pwm_trip`.
- R10: While `force_pwm` is high, light-load operation is left and never entered. From the weak state the low side turns fully on two clocks after `force_pwm` rises, and `zc_det` has no effect.
- R11: In light-load operation `cyc_tick` starts no pulse: the outputs in the weak state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse at the rising edge of the switching-cycle clock |
| pwm_trip | input | 1 | PWM comparator: sensed current plus ramp above error voltage |
| pfm_low | input | 1 | Light-load comparator: output below its threshold |
| ilim_trip | input | 1 | Peak current limit reached |
| zc_det | input | 1 | Inductor current has reached zero |
| en | input | 1 | Channel enable |
| force_pwm | input | 1 | Forces fixed-frequency operation |
| hs_on | output | 1 | High-side switch gate command |
| ls_on | output | 1 | Low-side switch fully on |
| ls_weak | output | 1 | Low-side device in weak current-source state |

## Verification
The hardest state to reach is the light-load regime. The only way in is a run of short PWM pulses with no long or current-limited pulse between them. The stimulus therefore sends a run of short trip-ended pulses, including one that lasts exactly the minimum on time, and breaks it once with a longer pulse. After each run it probes `zc_det` in the low-side phase, where only light-load operation reacts. The exit path is then reached by ordering stimulus around the cycle pulse: a request placed after a cycle pulse must keep light-load operation, and a second request before any cycle pulse must leave it.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_HS   = 3'd1,
    ST_DT   = 3'd2,
    ST_LS   = 3'd3,
    ST_WEAK = 3'd4
  } sw_state_t;
endpackage

// File: rtl/bss_run_ctr.sv
module bss_run_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/bss_mode_ctl.sv
module bss_mode_ctl #(
  parameter int MIN_ON_CYC = 8,
  parameter int ENTRY_CNT  = 4,
  parameter int CW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          force_pwm,
  input  logic          cyc_tick,
  input  logic          hs_start,
  input  logic          ev_pwm_end,
  input  logic          ev_ilim_end,
  input  logic          ev_pfm_req,
  input  logic [CW-1:0] on_cnt,
  output logic          pfm_mode
);
  localparam int LW = $clog2(ENTRY_CNT + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(MIN_ON_CYC - 1);
  localparam logic [LW-1:0] RUN_LAST = LW'(ENTRY_CNT - 1);

  logic [LW-1:0] light_q;
  logic          seen_q;
  logic          short_pulse;

  assign short_pulse = (on_cnt <= ON_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfm_mode <= 1'b0;
      light_q  <= '0;
      seen_q   <= 1'b0;
    end else if (!en) begin
      pfm_mode <= 1'b0;
      light_q  <= '0;
      seen_q   <= 1'b0;
    end else begin
      if (hs_start)      seen_q <= 1'b0;
      else if (cyc_tick) seen_q <= 1'b1;

      if (force_pwm) begin
        pfm_mode <= 1'b0;
        light_q  <= '0;
      end else if (ev_pfm_req && !seen_q) begin
        pfm_mode <= 1'b0;
        light_q  <= '0;
      end else if (ev_pwm_end) begin
        if (!short_pulse) begin
          light_q <= '0;
        end else if (light_q == RUN_LAST) begin
          pfm_mode <= 1'b1;
          light_q  <= '0;
        end else begin
          light_q <= light_q + 1'b1;
        end
      end else if (ev_ilim_end) begin
        light_q <= '0;
      end
    end
  end

  assert_pfm_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfm_mode) |-> $past(ev_pwm_end && short_pulse && !force_pwm));
  assert_force_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_pwm |=> !pfm_mode);
endmodule

// File: rtl/bss_fsm.sv
module bss_fsm
  import bss_pkg::*;
#(
  parameter int MIN_ON_CYC = 8,
  parameter int DEAD_CYC   = 3,
  parameter int CW         = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cyc_tick,
  input  logic          pwm_trip,
  input  logic          pfm_low,
  input  logic          ilim_trip,
  input  logic          zc_det,
  input  logic          pfm_mode,
  input  logic [CW-1:0] on_cnt,
  input  logic [CW-1:0] dt_cnt,
  output sw_state_t     st_q,
  output logic          hs_start,
  output logic          ev_pwm_end,
  output logic          ev_ilim_end,
  output logic          ev_pfm_req
);
  localparam logic [CW-1:0] ON_LAST = CW'(MIN_ON_CYC - 1);
  localparam logic [CW-1:0] DT_LAST = CW'(DEAD_CYC - 1);

  sw_state_t st_nx;

  always_comb begin
    st_nx       = st_q;
    ev_pwm_end  = 1'b0;
    ev_ilim_end = 1'b0;
    ev_pfm_req  = 1'b0;
    if (!en) begin
      st_nx = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:  if (cyc_tick) st_nx = ST_HS;
        ST_HS: begin
          if (ilim_trip) begin
            st_nx       = ST_DT;
            ev_ilim_end = 1'b1;
          end else if (pfm_mode) begin
            if (on_cnt == ON_LAST) st_nx = ST_DT;
          end else if (pwm_trip) begin
            st_nx      = ST_DT;
            ev_pwm_end = 1'b1;
          end
        end
        ST_DT: begin
          if (!pfm_mode && cyc_tick) st_nx = ST_HS;
          else if (dt_cnt == DT_LAST) st_nx = ST_LS;
        end
        ST_LS: begin
          if (pfm_mode) begin
            if (pfm_low) begin
              st_nx      = ST_HS;
              ev_pfm_req = 1'b1;
            end else if (zc_det) begin
              st_nx = ST_WEAK;
            end
          end else if (cyc_tick) begin
            st_nx = ST_HS;
          end
        end
        ST_WEAK: begin
          if (!pfm_mode) begin
            st_nx = ST_LS;
          end else if (pfm_low) begin
            st_nx      = ST_HS;
            ev_pfm_req = 1'b1;
          end
        end
        default: st_nx = ST_OFF;
      endcase
    end
  end

  assign hs_start = (st_nx == ST_HS) && (st_q != ST_HS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_nx;
  end

  assert_tick_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !pfm_mode && cyc_tick && st_q != ST_HS && st_q != ST_WEAK) |=> st_q == ST_HS);
  assert_no_direct_ls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_HS |=> st_q != ST_LS);
  assert_dead_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LS && $past(st_q) == ST_DT) |-> $past(dt_cnt) == DT_LAST);
  assert_ilim_cut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HS && ilim_trip) |=> st_q != ST_HS);
  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HS && en && !pfm_mode && !pwm_trip && !ilim_trip) |=> st_q == ST_HS);
  assert_min_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HS && en && pfm_mode && !ilim_trip && on_cnt < ON_LAST) |=> st_q == ST_HS);
  assert_tick_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WEAK && en && pfm_mode && !pfm_low) |=> st_q == ST_WEAK);
endmodule

// File: rtl/buck_switch_seq.sv
module buck_switch_seq
  import bss_pkg::*;
#(
  parameter int MIN_ON_CYC = 8,
  parameter int DEAD_CYC   = 3,
  parameter int ENTRY_CNT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_tick,
  input  logic pwm_trip,
  input  logic pfm_low,
  input  logic ilim_trip,
  input  logic zc_det,
  input  logic en,
  input  logic force_pwm,
  output logic hs_on,
  output logic ls_on,
  output logic ls_weak
);
  localparam int SPAN = (MIN_ON_CYC > DEAD_CYC) ? MIN_ON_CYC : DEAD_CYC;
  localparam int CW   = $clog2(SPAN + 2);

  sw_state_t      st_q;
  logic           pfm_mode, hs_start, ev_pwm_end, ev_ilim_end, ev_pfm_req;
  logic [CW-1:0]  on_cnt, dt_cnt;

  bss_run_ctr #(.W(CW)) u_on_ctr (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_HS), .cnt(on_cnt));

  bss_run_ctr #(.W(CW)) u_dt_ctr (
    .clk(clk), .rst_n(rst_n), .run(st_q == ST_DT), .cnt(dt_cnt));

  bss_fsm #(.MIN_ON_CYC(MIN_ON_CYC), .DEAD_CYC(DEAD_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(en), .cyc_tick(cyc_tick),
    .pwm_trip(pwm_trip), .pfm_low(pfm_low), .ilim_trip(ilim_trip),
    .zc_det(zc_det), .pfm_mode(pfm_mode), .on_cnt(on_cnt), .dt_cnt(dt_cnt),
    .st_q(st_q), .hs_start(hs_start), .ev_pwm_end(ev_pwm_end),
    .ev_ilim_end(ev_ilim_end), .ev_pfm_req(ev_pfm_req));

  bss_mode_ctl #(.MIN_ON_CYC(MIN_ON_CYC), .ENTRY_CNT(ENTRY_CNT), .CW(CW)) u_mode (
    .clk(clk), .rst_n(rst_n), .en(en), .force_pwm(force_pwm),
    .cyc_tick(cyc_tick), .hs_start(hs_start), .ev_pwm_end(ev_pwm_end),
    .ev_ilim_end(ev_ilim_end), .ev_pfm_req(ev_pfm_req), .on_cnt(on_cnt),
    .pfm_mode(pfm_mode));

  assign hs_on   = (st_q == ST_HS);
  assign ls_on   = (st_q == ST_LS);
  assign ls_weak = (st_q == ST_WEAK) || ((st_q == ST_HS) && pfm_mode);

  assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_on && !ls_on && !ls_weak));
  assert_no_shoot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));
  assert_weak_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_on && ls_weak));
endmodule

// File: tb/buck_switch_seq_tb.sv
module buck_switch_seq_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_tick = 0, pwm_trip = 0, pfm_low = 0, ilim_trip = 0;
  logic zc_det = 0, en = 0, force_pwm = 0;
  logic hs_on, ls_on, ls_weak;

  typedef struct { int at; logic [2:0] val; string tag; } exp_t;
  exp_t sb_q[$];
  int cyc = 0, checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  buck_switch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .pwm_trip(pwm_trip),
    .pfm_low(pfm_low), .ilim_trip(ilim_trip), .zc_det(zc_det), .en(en),
    .force_pwm(force_pwm), .hs_on(hs_on), .ls_on(ls_on), .ls_weak(ls_weak));

  // monitor: pops expected items as their cycle comes up
  always @(posedge clk) begin
    exp_t e;
    #(CLK_P/4);
    cyc++;
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      e = sb_q.pop_front();
      checks++;
      if (e.at != cyc || {hs_on, ls_on, ls_weak} != e.val) begin
        failures++;
        $display("FAIL %s cyc=%0d hs/ls/weak actual=%b expected=%b", e.tag, cyc,
                 {hs_on, ls_on, ls_weak}, e.val);
      end
    end
  end

  task automatic push(int at, logic [2:0] v, string tag);
    exp_t e;
    e.at = at; e.val = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic pwm_pulse(int on_len, string tag);
    int c;
    c = cyc; cyc_tick = 1; push(c + 1, 3'b100, tag);
    @(negedge clk); cyc_tick = 0;
    repeat (on_len - 1) @(negedge clk);
    c = cyc; pwm_trip = 1;
    push(c + 1, 3'b000, "R2"); push(c + 3, 3'b000, "R3"); push(c + 4, 3'b010, "R3");
    @(negedge clk); pwm_trip = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic zc_probe(bit light, string tag);
    int c;
    c = cyc; zc_det = 1;
    push(c + 1, light ? 3'b001 : 3'b010, tag);
    @(negedge clk); zc_det = 0;
    @(negedge clk);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    push(cyc + 1, 3'b000, "R1");
    @(negedge clk);
    // R1: tick while disabled starts nothing
    c = cyc; cyc_tick = 1; push(c + 1, 3'b000, "R1"); push(c + 2, 3'b000, "R1");
    @(negedge clk); cyc_tick = 0; @(negedge clk);
    en = 1; force_pwm = 1;
    @(negedge clk);
    pwm_pulse(4, "R2");
    // R4: current limit cuts the pulse
    c = cyc; cyc_tick = 1; push(c + 1, 3'b100, "R4");
    @(negedge clk); cyc_tick = 0; @(negedge clk);
    c = cyc; ilim_trip = 1; push(c + 1, 3'b000, "R4"); push(c + 4, 3'b010, "R4");
    @(negedge clk); ilim_trip = 0; repeat (5) @(negedge clk);
    // R5: 100% duty across ticks
    c = cyc; cyc_tick = 1; push(c + 1, 3'b100, "R5");
    @(negedge clk); cyc_tick = 0; repeat (9) @(negedge clk);
    c = cyc; cyc_tick = 1; push(c + 1, 3'b100, "R5"); push(c + 6, 3'b100, "R5");
    @(negedge clk); cyc_tick = 0; repeat (6) @(negedge clk);
    c = cyc; pwm_trip = 1; push(c + 1, 3'b000, "R5"); push(c + 4, 3'b010, "R3");
    @(negedge clk); pwm_trip = 0; repeat (5) @(negedge clk);
    // R6: automatic entry with a run broken by a long pulse
    force_pwm = 0;
    pwm_pulse(3, "R6"); pwm_pulse(8, "R6"); pwm_pulse(3, "R6");
    pwm_pulse(9, "R6");
    pwm_pulse(3, "R6"); pwm_pulse(3, "R6"); pwm_pulse(8, "R6");
    zc_probe(0, "R6");
    pwm_pulse(3, "R6");
    zc_probe(1, "R6");
    // R11: tick ignored in light load
    c = cyc; cyc_tick = 1; push(c + 1, 3'b001, "R11"); push(c + 2, 3'b001, "R11");
    @(negedge clk); cyc_tick = 0; @(negedge clk);
    // R7/R8: light-load pulse, trip ignored, fixed width
    c = cyc; pfm_low = 1;
    push(c + 1, 3'b101, "R7"); push(c + 8, 3'b101, "R7");
    push(c + 9, 3'b000, "R7"); push(c + 12, 3'b010, "R8");
    @(negedge clk); pfm_low = 0; pwm_trip = 1;
    repeat (3) @(negedge clk); pwm_trip = 0;
    repeat (9) @(negedge clk);
    zc_probe(1, "R8");
    // R9: request without an intervening tick leaves light load
    c = cyc; pfm_low = 1; push(c + 1, 3'b100, "R9");
    @(negedge clk); pfm_low = 0; repeat (2) @(negedge clk);
    c = cyc; pwm_trip = 1; push(c + 1, 3'b000, "R9"); push(c + 4, 3'b010, "R9");
    @(negedge clk); pwm_trip = 0; repeat (5) @(negedge clk);
    zc_probe(0, "R9");
    pwm_pulse(3, "R6"); pwm_pulse(3, "R6"); pwm_pulse(3, "R6");
    zc_probe(1, "R6");
    // R10: forced PWM from the weak state
    c = cyc; force_pwm = 1; push(c + 2, 3'b010, "R10");
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) pwm_pulse(3, "R10");
    zc_probe(0, "R10");
    // R1: disable during a pulse
    c = cyc; cyc_tick = 1; push(c + 1, 3'b100, "R2");
    @(negedge clk); cyc_tick = 0; @(negedge clk);
    c = cyc; en = 0; push(c + 1, 3'b000, "R1");
    @(negedge clk); cyc_tick = 1; push(c + 3, 3'b000, "R1");
    @(negedge clk); cyc_tick = 0;
    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL R1 pending expectations actual=%0d expected=0", sb_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule